// File: doc/BRIEF.md
# Decimal Digit Two-Wire Bus Master

This block is a bus master for a two-wire serial bus with one target device. A single transaction carries a five-bit payload: a decimal digit from zero to nine, followed by a direction flag. The bus clock comes from a counter that runs off the system clock. That counter runs only while a transaction is in progress. Outside a transaction neither wire is driven and no bus clock edge occurs.

Each bit slot is split into four equal quarters of `QTR_CLKS` system clocks. SCL is held low for the first two quarters and released for the last two. The default of 125 gives 500 clocks per slot, which is 100 kHz at 50 MHz.

The wires are open drain. The block outputs a drive-low enable for each wire. It reads SDA back through a synchronizer. After the payload the target answers in an acknowledge slot. On a read, the master then clocks in a four-bit digit from the target and refuses it with a high bit. Every transaction ends in a stop condition and a one-cycle `done` pulse.

Top module: `i2c_digit_master`

## Requirements
- R1: After reset, and on every cycle where the block has been idle for at least one cycle, `busy` is low and both `scl_oe` and `sda_oe` are low (lines released). SCL shows no edge while idle.
- R2: If `start_req` is high while idle and `digit` is 9 or less, the request is accepted. `busy` rises on the next cycle. A start condition follows: SDA falls while SCL is high.
- R3: One SCL period is 4*QTR_CLKS system clocks, with SCL high for 2*QTR_CLKS of them. From the request cycle to the `done` pulse takes 1 + N*4*QTR_CLKS cycles. N is 8 slots for a write or a refused acknowledge, and 13 slots for an acknowledged read.
- R4: The first five clocked bits are digit bit 3, bit 2, bit 1, bit 0, then the direction flag (1 = read, 0 = write). SDA changes only while SCL is low.
- R5: On the sixth SCL clock the master releases SDA and samples it in the middle of the high half. A low level is an acknowledge.
- R6: If SDA is high during the acknowledge clock, `ack_err` goes high and stays high until the next accepted request. No read bits are clocked, and a stop and `done` follow.
- R7: On an acknowledged read, clocks 7 to 10 shift in four bits from the target, most significant first. Clock 11 carries a released (high) SDA as a refusal, followed by a stop. `rd_digit` shows the received value when `done` is high.
- R8: The stop condition is SDA rising while SCL is high. It is followed by a single-cycle `done` with `busy` low in that same cycle.
- R9: A request with `digit` above 9 raises `bad_digit` for exactly one cycle, on the cycle after the request. `busy` stays low and the bus stays released.
- R10: `start_req` is ignored while `busy` is high. The payload on the bus stays the one latched when the request was accepted.
- R11: A write, or a refused acknowledge, leaves `rd_digit` unchanged. Each accepted request clears `ack_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Request a transaction; sampled while idle |
| digit | input | 4 | Decimal digit to send, 0 to 9 |
| rw | input | 1 | Direction flag: 1 read, 0 write |
| sda_in | input | 1 | Level sensed on the SDA wire |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse when the stop completes |
| ack_err | output | 1 | Target did not acknowledge the last transaction |
| bad_digit | output | 1 | One-cycle pulse for a rejected digit above 9 |
| rd_digit | output | 4 | Digit received by the last acknowledged read |

## Verification
A slot counter that skips a value or repeats one changes the number of SCL rising edges between start and stop. It also moves the `done` pulse off its exact cycle, so the fault is visible within the same transaction. A phase counter out of step shows up as a shortened high or low time at the next SCL edge. It also shows up as SDA moving while SCL is high, which the bus-level target model reads as a false start or stop. A latched payload or read shift register holding the wrong bits appears at `done` as a wrong decoded frame or a wrong `rd_digit`. A direction or acknowledge flag holding the wrong value changes the slot count of that transaction.

// File: rtl/i2cd_pkg.sv
package i2cd_pkg;

    localparam int DIGIT_W = 4;

    // Slot numbering inside the transfer state
    localparam logic [3:0] SLOT_LAST_TX = 4'd4;
    localparam logic [3:0] SLOT_ACK     = 4'd5;
    localparam logic [3:0] SLOT_NACK    = 4'd10;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_XFER,
        ST_STOP
    } state_t;

    typedef struct packed {
        logic [DIGIT_W-1:0] digit;
        logic               rw;
    } frame_t;

    function automatic logic digit_ok(input logic [DIGIT_W-1:0] d);
        return d <= 4'd9;
    endfunction

    // Payload bit for transmit slot s (0..4), digit MSB first, then direction
    function automatic logic frame_bit(input frame_t f, input logic [2:0] s);
        logic [DIGIT_W:0] v;
        v = f;
        return v[3'd4 - s];
    endfunction

endpackage

// File: rtl/i2cd_quarter_timer.sv
module i2cd_quarter_timer #(
    parameter int QTR_CLKS = 125
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    output logic [1:0] q,
    output logic       q_last
);
    localparam int CW = (QTR_CLKS > 1) ? $clog2(QTR_CLKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(QTR_CLKS - 1);

    logic [CW-1:0] cnt;

    assign q_last = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            q   <= 2'd0;
        end else if (q_last) begin
            cnt <= '0;
            q   <= q + 2'd1;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/i2cd_line_sync.sv
module i2cd_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sh <= '1;
                else     sh <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) sh <= '1;
                else     sh <= {sh[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = sh[STAGES-1];
endmodule

// File: rtl/i2c_digit_master.sv
module i2c_digit_master
    import i2cd_pkg::*;
#(
    parameter int QTR_CLKS    = 125,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_req,
    input  logic [3:0]   digit,
    input  logic         rw,
    input  logic         sda_in,
    output logic         scl_oe,
    output logic         sda_oe,
    output logic         busy,
    output logic         done,
    output logic         ack_err,
    output logic         bad_digit,
    output logic [3:0]   rd_digit
);
    state_t             state;
    logic [3:0]         slot;
    frame_t             frame;
    logic [1:0]         q;
    logic               q_last;
    logic               sample_stb;
    logic               slot_end;
    logic               sda_s;
    logic               nack_seen;
    logic [DIGIT_W-1:0] rd_sh;
    logic               sda_next;

    i2cd_quarter_timer #(.QTR_CLKS(QTR_CLKS)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run    (state != ST_IDLE),
        .q      (q),
        .q_last (q_last)
    );

    i2cd_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (sda_in),
        .q   (sda_s)
    );

    assign sample_stb = q_last && (q == 2'd2);
    assign slot_end   = q_last && (q == 2'd3);
    assign busy       = (state != ST_IDLE);

    // SCL low for quarters 0 and 1 of every clocked slot
    always_comb begin
        unique case (state)
            ST_XFER, ST_STOP: scl_oe = (q < 2'd2);
            default:          scl_oe = 1'b0;
        endcase
    end

    // SDA request, registered one cycle behind SCL so it moves after SCL falls
    always_comb begin
        unique case (state)
            ST_START: sda_next = (q >= 2'd2);
            ST_XFER:  sda_next = (slot <= SLOT_LAST_TX) ? !frame_bit(frame, slot[2:0]) : 1'b0;
            ST_STOP:  sda_next = (q <= 2'd2);
            default:  sda_next = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            slot      <= 4'd0;
            frame     <= '0;
            nack_seen <= 1'b0;
            rd_sh     <= '0;
            rd_digit  <= '0;
            ack_err   <= 1'b0;
            done      <= 1'b0;
            bad_digit <= 1'b0;
            sda_oe    <= 1'b0;
        end else begin
            done      <= 1'b0;
            bad_digit <= 1'b0;
            sda_oe    <= sda_next;
            unique case (state)
                ST_IDLE: begin
                    if (start_req) begin
                        if (digit_ok(digit)) begin
                            frame     <= '{digit: digit, rw: rw};
                            ack_err   <= 1'b0;
                            nack_seen <= 1'b0;
                            slot      <= 4'd0;
                            state     <= ST_START;
                        end else begin
                            bad_digit <= 1'b1;
                        end
                    end
                end
                ST_START: begin
                    if (slot_end) begin
                        state <= ST_XFER;
                        slot  <= 4'd0;
                    end
                end
                ST_XFER: begin
                    if (sample_stb) begin
                        if (slot == SLOT_ACK)
                            nack_seen <= sda_s;
                        else if (slot > SLOT_ACK && slot < SLOT_NACK)
                            rd_sh <= {rd_sh[DIGIT_W-2:0], sda_s};
                    end
                    if (slot_end) begin
                        if (slot == SLOT_ACK) begin
                            if (nack_seen) begin
                                ack_err <= 1'b1;
                                state   <= ST_STOP;
                            end else if (frame.rw) begin
                                slot <= slot + 4'd1;
                            end else begin
                                state <= ST_STOP;
                            end
                        end else if (slot == SLOT_NACK) begin
                            rd_digit <= rd_sh;
                            state    <= ST_STOP;
                        end else begin
                            slot <= slot + 4'd1;
                        end
                    end
                end
                ST_STOP: begin
                    if (slot_end) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/i2c_digit_master_chk.sv
module i2c_digit_master_chk (
    input logic       clk,
    input logic       rst,
    input logic       start_req,
    input logic [3:0] digit,
    input logic       busy,
    input logic       done,
    input logic       bad_digit,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic       in_xfer
);
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(busy)) |-> (!scl_oe && !sda_oe)); // R1

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (start_req && !busy && digit <= 4'd9) |=> busy); // R2

    AST_SDA_STABLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (in_xfer && $past(in_xfer) && !scl_oe && !$past(scl_oe)) |-> $stable(sda_oe)); // R4

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R8

    AST_BAD_STAYS_IDLE: assert property (@(posedge clk) disable iff (rst)
        bad_digit |-> (!busy && !done)); // R9
endmodule

bind i2c_digit_master i2c_digit_master_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .start_req (start_req),
    .digit     (digit),
    .busy      (busy),
    .done      (done),
    .bad_digit (bad_digit),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .in_xfer   (state == i2cd_pkg::ST_XFER)
);

// File: tb/i2c_digit_master_bench.sv
module i2c_digit_master_bench;
    localparam int Q = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic       start_req = 1'b0;
    logic [3:0] digit = 4'd0;
    logic       rw = 1'b0;
    logic       scl_oe, sda_oe, busy, done, ack_err, bad_digit;
    logic [3:0] rd_digit;
    logic       s_pull = 1'b0;
    logic       sda_bus, scl_bus;

    assign sda_bus = !(sda_oe || s_pull);
    assign scl_bus = !scl_oe;

    i2c_digit_master #(.QTR_CLKS(Q)) u_i2c_digit_master (
        .clk(clk), .rst(rst), .start_req(start_req), .digit(digit), .rw(rw),
        .sda_in(sda_bus), .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy),
        .done(done), .ack_err(ack_err), .bad_digit(bad_digit), .rd_digit(rd_digit)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    typedef struct {
        logic [3:0] d;
        logic       rw;
        logic       ack;
        logic [3:0] rdv;
    } txn_t;
    txn_t exp_q[$];

    // Target model state
    logic       cfg_ack = 1'b1;
    logic [3:0] cfg_rd = 4'd0;
    int         cyc = 0;
    int         nrise = 0;
    logic [4:0] rxsh = '0;
    logic       seen_start = 0, seen_stop = 0, nack_bit = 0;
    int         t_rise = 0, period = 0, hi_time = 0;
    logic       prev_scl = 1, prev_sda = 1;
    logic [3:0] last_rd = 4'd0;

    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
        if (!rst) begin
            if (prev_scl && scl_bus && prev_sda && !sda_bus) begin
                seen_start = 1; seen_stop = 0; nrise = 0; rxsh = '0;
                period = 0; hi_time = 0; nack_bit = 0;
            end
            if (prev_scl && scl_bus && !prev_sda && sda_bus) seen_stop = 1;
            if (!prev_scl && scl_bus) begin
                nrise++;
                if (nrise == 2 && period == 0) period = cyc - t_rise;
                t_rise = cyc;
                if (nrise <= 5) rxsh = {rxsh[3:0], sda_bus};
                if (nrise == 11) nack_bit = sda_bus;
            end
            if (prev_scl && !scl_bus) begin
                if (nrise == 1 && hi_time == 0) hi_time = cyc - t_rise;
                if (nrise == 5) s_pull = cfg_ack;
                else if (nrise >= 6 && nrise <= 9 && rxsh[0] && cfg_ack) s_pull = !cfg_rd[9 - nrise];
                else s_pull = 0;
            end
        end
        prev_scl = scl_bus;
        prev_sda = sda_bus;
    end

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && done) begin
            if (exp_q.size() == 0) begin
                chk(0, "R8", "unexpected done", 1, 0);
            end else begin
                txn_t t;
                int   er;
                t = exp_q.pop_front();
                er = (t.rw && t.ack) ? 12 : 7;
                chk(seen_start == 1, "R2", "start seen", seen_start, 1);
                chk(rxsh == {t.d, t.rw}, "R4", "frame bits", rxsh, {t.d, t.rw});
                chk(ack_err == !t.ack, t.ack ? "R5" : "R6", "ack_err", ack_err, !t.ack);
                chk(nrise == er, t.ack ? "R7" : "R6", "SCL rises", nrise, er);
                if (t.rw && t.ack) begin
                    last_rd = t.rdv;
                    chk(nack_bit == 1, "R7", "refusal bit", nack_bit, 1);
                end
                chk(rd_digit == last_rd, (t.rw && t.ack) ? "R7" : "R11", "rd_digit", rd_digit, last_rd);
                chk(seen_stop == 1, "R8", "stop seen", seen_stop, 1);
                chk(busy == 0, "R8", "busy at done", busy, 0);
                chk(period == 4 * Q, "R3", "SCL period", period, 4 * Q);
                chk(hi_time == 2 * Q, "R3", "SCL high time", hi_time, 2 * Q);
                chk(!scl_oe && !sda_oe, "R1", "lines at done", {scl_oe, sda_oe}, 0);
            end
        end
    end

    task automatic run_txn(input logic [3:0] d, input logic r, input logic a, input logic [3:0] rdv, input bit poke);
        txn_t t;
        int lat, slots;
        t = '{d: d, rw: r, ack: a, rdv: rdv};
        slots = (r && a) ? 13 : 8;
        @(negedge clk);
        cfg_ack = a; cfg_rd = rdv;
        exp_q.push_back(t);
        digit = d; rw = r; start_req = 1;
        @(negedge clk);
        lat = 1;
        start_req = 0;
        chk(busy == 1, "R2", "busy after accept", busy, 1);
        if (poke) begin
            repeat (3) @(negedge clk);
            lat += 3;
            digit = 4'd3; rw = !r; start_req = 1;   // R10: must be ignored
            @(negedge clk);
            lat++;
            start_req = 0;
        end
        while (!done) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == 1 + slots * 4 * Q, "R3", "request to done", lat, 1 + slots * 4 * Q);
        repeat (3) @(negedge clk);
    endtask

    task automatic bad_req(input logic [3:0] d);
        bit quiet;
        @(negedge clk);
        digit = d; rw = 0; start_req = 1;
        @(negedge clk);
        start_req = 0;
        chk(bad_digit == 1 && busy == 0, "R9", "bad_digit pulse", {bad_digit, busy}, 2);
        @(negedge clk);
        chk(bad_digit == 0, "R9", "bad_digit width", bad_digit, 0);
        quiet = 1;
        for (int i = 0; i < 40; i++) begin
            if (busy || scl_oe || sda_oe || done) quiet = 0;
            @(negedge clk);
        end
        chk(quiet, "R9", "bus quiet after reject", quiet, 1);
        chk(exp_q.size() == 0, "R9", "no transaction", exp_q.size(), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(!busy && !scl_oe && !sda_oe && !done, "R1", "reset outputs",
            {busy, scl_oe, sda_oe, done}, 0);
        chk(ack_err == 0 && rd_digit == 0 && bad_digit == 0, "R1", "reset flags",
            {ack_err, rd_digit, bad_digit}, 0);
        run_txn(4'd0, 0, 1, 4'd0, 0);
        run_txn(4'd9, 0, 1, 4'd0, 0);
        run_txn(4'd5, 1, 1, 4'hA, 0);
        run_txn(4'd6, 0, 0, 4'd0, 0);   // R6 refused write
        run_txn(4'd2, 1, 0, 4'h5, 0);   // R6 refused read, R11 rd_digit kept
        run_txn(4'd8, 1, 1, 4'h3, 1);   // R10 poke while busy
        run_txn(4'd1, 0, 1, 4'd0, 1);   // R10, R11 ack_err cleared
        bad_req(4'd10);
        bad_req(4'd15);
        run_txn(4'd7, 1, 1, 4'hF, 0);
        run_txn(4'd3, 1, 1, 4'h0, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule